// File: doc/BRIEF.md
# Inter-Processor Interrupt and Mailbox Unit

This block lets cores of a small cluster signal each other. Every core owns a 32-bit pending-status word and eight 32-bit mailbox words. One register write port carries all requests. A core can set or clear bits of its own status word. It can also issue one 64-bit send command, which either raises one status bit on another core or deposits a word into one of that core's mailboxes.

A mailbox deposit may keep selected bytes of the old word. A byte-keep mask in the command picks them, and the remaining bytes come from the upper half of the command. Each core has an interrupt line that is high while its status word is nonzero. A one-cycle event pulse marks the moment that word leaves zero. A command that names a core the unit does not have is dropped and flagged on an error pulse. Status words and mailbox words can be read back over a separate read port with one cycle of latency.

Top module: `ipi_mailbox_unit`

## Requirements
- R1: After reset every status word and mailbox word reads 0, and `irq`, `irq_edge` and `send_err` are low.
- R2: A write to address 0x10 is a signal-send. The target core is `wr_data[25:16]` and the vector is `wr_data[4:0]`. Bit `1 << vector` is OR-ed into the target's status word, and the new value is visible from the cycle after the write.
- R3: `irq[c]` is high exactly while the status word of core `c` is nonzero.
- R4: `irq_edge[c]` is high for one cycle, the cycle after a write, only when that write moves core `c`'s status from zero to nonzero. A write that adds bits to an already nonzero status produces no pulse.
- R5: A write to address 0x08 ORs `wr_data[31:0]` into the status word of the issuing core `wr_core`, under the same pulse rule as R4.
- R6: A write to address 0x0C clears, in the status word of the issuing core only, every bit that is 1 in `wr_data[31:0]`. Other cores are unaffected.
- R7: A write to address 0x18 is a mail-send. The target core is `wr_data[25:16]` and the mailbox index is `wr_data[4:2]`. Mailbox `i` reads at address 0x20 + 4*i.
- R8: In a mail-send, keep bit `wr_data[27+b]` = 1 keeps byte `b` (bits 8b+7:8b) of the old mailbox word. When the keep bit is 0, byte `b` takes `wr_data[32+8b+7:32+8b]`. A keep mask of all ones leaves the word unchanged.
- R9: A signal-send or mail-send whose target is not below NCORE changes no status or mailbox word. It raises `send_err` for the one cycle after the write.
- R10: `rd_en` returns `rd_valid` high with `rd_data` in the next cycle. Address 0x00 returns the status word of `rd_core`, 0x20..0x3C return its mailbox words, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_core | input | CW | Issuing core of the write |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 64 | Write data / send command |
| rd_en | input | 1 | Read strobe |
| rd_core | input | CW | Core whose registers are read |
| rd_addr | input | 8 | Read register address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq | output | NCORE | Per-core interrupt, high while status nonzero |
| irq_edge | output | NCORE | Per-core zero-to-nonzero event pulse |
| send_err | output | 1 | Pulse for a send with an absent target |

## Verification
Every write takes effect at the clock edge that samples it. Status, `irq`, `irq_edge` and `send_err` therefore reflect a write in the cycle that follows, and read data arrives one cycle after `rd_en`. The bench drives every input on the falling edge. It checks write results on the next falling edge, before the one-cycle pulses can drop. Expected read values are queued when the read is issued and popped by a monitor on the falling edge where `rd_valid` is high, so every value is compared in the cycle it is due.

// File: rtl/ipi_mailbox_pkg.sv
package ipi_mailbox_pkg;
    localparam int WORD_W     = 32;
    localparam int CMD_W      = 64;
    localparam int ADDR_W     = 8;
    localparam int MBOX_N     = 8;
    localparam int MBOX_IDX_W = $clog2(MBOX_N);
    localparam int VEC_W      = 5;
    localparam int TGT_W      = 10;
    localparam int TGT_LSB    = 16;
    localparam int KEEP_W     = WORD_W / 8;
    localparam int KEEP_LSB   = 27;

    localparam logic [ADDR_W-1:0] A_STATUS    = 8'h00;
    localparam logic [ADDR_W-1:0] A_SET       = 8'h08;
    localparam logic [ADDR_W-1:0] A_CLEAR     = 8'h0C;
    localparam logic [ADDR_W-1:0] A_SIG_SEND  = 8'h10;
    localparam logic [ADDR_W-1:0] A_MAIL_SEND = 8'h18;
    localparam logic [ADDR_W-1:0] A_MBOX_BASE = 8'h20;

    typedef logic [MBOX_N-1:0][WORD_W-1:0] mbox_t;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        mbox_t             mbox;
        logic              edge_ev;
    } slot_state_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rd_state_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_mailbox_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                  wr_en,
    input  logic [CW-1:0]         wr_core,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CMD_W-1:0]      wr_data,
    output logic [NCORE-1:0]      set_en,
    output logic [NCORE-1:0]      clr_en,
    output logic [NCORE-1:0]      mb_en,
    output logic [WORD_W-1:0]     bit_mask,
    output logic [MBOX_IDX_W-1:0] mb_idx,
    output logic [KEEP_W-1:0]     mb_keep,
    output logic [WORD_W-1:0]     mb_payload,
    output logic                  bad_target
);
    logic [TGT_W-1:0] target;
    logic [VEC_W-1:0] vec;
    logic             tgt_ok;

    assign target     = wr_data[TGT_LSB +: TGT_W];
    assign vec        = wr_data[VEC_W-1:0];
    assign tgt_ok     = (target < TGT_W'(NCORE));
    assign mb_idx     = wr_data[2 +: MBOX_IDX_W];
    assign mb_keep    = wr_data[KEEP_LSB +: KEEP_W];
    assign mb_payload = wr_data[CMD_W-1:WORD_W];

    always_comb begin
        set_en     = '0;
        clr_en     = '0;
        mb_en      = '0;
        bit_mask   = wr_data[WORD_W-1:0];
        bad_target = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                A_SET: begin
                    for (int i = 0; i < NCORE; i++)
                        if (wr_core == CW'(i)) set_en[i] = 1'b1;
                end
                A_CLEAR: begin
                    for (int i = 0; i < NCORE; i++)
                        if (wr_core == CW'(i)) clr_en[i] = 1'b1;
                end
                A_SIG_SEND: begin
                    bit_mask = WORD_W'(1) << vec;
                    if (tgt_ok) begin
                        for (int i = 0; i < NCORE; i++)
                            if (target == TGT_W'(i)) set_en[i] = 1'b1;
                    end else begin
                        bad_target = 1'b1;
                    end
                end
                A_MAIL_SEND: begin
                    if (tgt_ok) begin
                        for (int i = 0; i < NCORE; i++)
                            if (target == TGT_W'(i)) mb_en[i] = 1'b1;
                    end else begin
                        bad_target = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
    import ipi_mailbox_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic                  clr_en,
    input  logic                  mb_en,
    input  logic [WORD_W-1:0]     bit_mask,
    input  logic [MBOX_IDX_W-1:0] mb_idx,
    input  logic [KEEP_W-1:0]     mb_keep,
    input  logic [WORD_W-1:0]     mb_payload,
    output logic [WORD_W-1:0]     status_o,
    output mbox_t                 mbox_o,
    output logic                  irq_o,
    output logic                  irq_edge_o
);
    slot_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_en) s_d.status = s_q.status & ~bit_mask;
        if (set_en) s_d.status = s_d.status | bit_mask;
        if (mb_en) begin
            for (int b = 0; b < KEEP_W; b++)
                if (!mb_keep[b])
                    s_d.mbox[mb_idx][8*b +: 8] = mb_payload[8*b +: 8];
        end
        s_d.edge_ev = (s_q.status == '0) && (s_d.status != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o   = s_q.status;
    assign mbox_o     = s_q.mbox;
    assign irq_o      = |s_q.status;
    assign irq_edge_o = s_q.edge_ev;
endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
    import ipi_mailbox_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [CW-1:0]                rd_core,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NCORE-1:0][WORD_W-1:0] status_all,
    input  mbox_t [NCORE-1:0]            mbox_all,
    output logic                         rd_valid,
    output logic [WORD_W-1:0]            rd_data
);
    localparam int MB_SPAN = MBOX_N * (WORD_W / 8);

    rd_state_t r_d, r_q;
    logic [WORD_W-1:0] sel_status;
    mbox_t             sel_mbox;
    logic [ADDR_W-1:0] mb_off;

    assign mb_off = rd_addr - A_MBOX_BASE;

    always_comb begin
        sel_status = '0;
        sel_mbox   = '0;
        for (int c = 0; c < NCORE; c++) begin
            if (rd_core == CW'(c)) begin
                sel_status = status_all[c];
                sel_mbox   = mbox_all[c];
            end
        end
        r_d.valid = rd_en;
        r_d.data  = '0;
        if (rd_en) begin
            if (rd_addr == A_STATUS)
                r_d.data = sel_status;
            else if (rd_addr >= A_MBOX_BASE && mb_off < ADDR_W'(MB_SPAN)
                     && mb_off[1:0] == 2'b00)
                r_d.data = sel_mbox[mb_off[2 +: MBOX_IDX_W]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.valid;
    assign rd_data  = r_q.data;
endmodule

// File: rtl/ipi_mailbox_unit.sv
module ipi_mailbox_unit
    import ipi_mailbox_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_core,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [CW-1:0]     rd_core,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [NCORE-1:0]  irq,
    output logic [NCORE-1:0]  irq_edge,
    output logic              send_err
);
    logic [NCORE-1:0]             set_en, clr_en, mb_en;
    logic [WORD_W-1:0]            bit_mask, mb_payload;
    logic [MBOX_IDX_W-1:0]        mb_idx;
    logic [KEEP_W-1:0]            mb_keep;
    logic                         bad_target;
    logic [NCORE-1:0][WORD_W-1:0] status_all;
    mbox_t [NCORE-1:0]            mbox_all;
    logic                         err_d, err_q;

    ipi_cmd_decode #(.NCORE(NCORE)) u_dec (
        .wr_en      (wr_en),
        .wr_core    (wr_core),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .set_en     (set_en),
        .clr_en     (clr_en),
        .mb_en      (mb_en),
        .bit_mask   (bit_mask),
        .mb_idx     (mb_idx),
        .mb_keep    (mb_keep),
        .mb_payload (mb_payload),
        .bad_target (bad_target)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_slot
        ipi_core_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_en     (set_en[c]),
            .clr_en     (clr_en[c]),
            .mb_en      (mb_en[c]),
            .bit_mask   (bit_mask),
            .mb_idx     (mb_idx),
            .mb_keep    (mb_keep),
            .mb_payload (mb_payload),
            .status_o   (status_all[c]),
            .mbox_o     (mbox_all[c]),
            .irq_o      (irq[c]),
            .irq_edge_o (irq_edge[c])
        );
    end

    ipi_read_port #(.NCORE(NCORE)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_core    (rd_core),
        .rd_addr    (rd_addr),
        .status_all (status_all),
        .mbox_all   (mbox_all),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    always_comb err_d = bad_target;

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign send_err = err_q;
endmodule

// File: rtl/ipi_mailbox_unit_chk.sv
module ipi_mailbox_unit_chk
    import ipi_mailbox_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [CW-1:0]                wr_core,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [WORD_W-1:0]            wr_lo,
    input logic                         rd_en,
    input logic                         rd_valid,
    input logic [NCORE-1:0]             irq,
    input logic [NCORE-1:0]             irq_edge,
    input logic                         send_err,
    input logic [NCORE-1:0][WORD_W-1:0] status_all
);
    logic [TGT_W-1:0] tgt;
    logic             is_send;
    assign tgt     = wr_lo[TGT_LSB +: TGT_W];
    assign is_send = wr_en && (wr_addr == A_SIG_SEND || wr_addr == A_MAIL_SEND);

    AST_BAD_TARGET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_send && tgt >= TGT_W'(NCORE)) |=> (send_err && $stable(status_all))) // R9
        else $error("bad target not flagged");

    AST_ERR_NEEDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        send_err |-> $past(wr_en)) // R9
        else $error("spurious error");

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid) // R10
        else $error("read data late");

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        AST_SIG_SEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_SIG_SEND && tgt == TGT_W'(c))
            |=> status_all[c][$past(wr_lo[VEC_W-1:0])]) // R2
            else $error("signal-send bit missing");

        AST_EDGE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            irq_edge[c] |-> (irq[c] && !$past(irq[c]))) // R4
            else $error("event pulse without zero-to-nonzero");

        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_CLEAR && wr_core == CW'(c))
            |=> ((status_all[c] & $past(wr_lo)) == '0)) // R6
            else $error("clear left bits");
    end
endmodule

bind ipi_mailbox_unit ipi_mailbox_unit_chk #(.NCORE(NCORE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_core    (wr_core),
    .wr_addr    (wr_addr),
    .wr_lo      (wr_data[31:0]),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .irq        (irq),
    .irq_edge   (irq_edge),
    .send_err   (send_err),
    .status_all (status_all)
);

// File: tb/tb_ipi_mailbox_unit.sv
module tb_ipi_mailbox_unit;
    localparam int NC = 4;
    localparam int CW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [CW-1:0] wr_core = '0;
    logic [7:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [CW-1:0] rd_core = '0;
    logic [7:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [NC-1:0] irq, irq_edge;
    logic        send_err;

    always #5 clk = ~clk;

    ipi_mailbox_unit #(.NCORE(NC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_core(wr_core),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_core(rd_core), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq(irq), .irq_edge(irq_edge), .send_err(send_err)
    );

    int checks = 0;
    int failures = 0;
    logic [31:0] st_m [NC];
    logic [31:0] mb_m [NC][8];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] cmd(input int tgt, input logic [3:0] keep,
                                        input logic [4:0] low, input logic [31:0] pay);
        logic [63:0] d = '0;
        d[63:32] = pay;
        d[30:27] = keep;
        d[25:16] = tgt[9:0];
        d[4:0]   = low;
        return d;
    endfunction

    function automatic logic [NC-1:0] irq_model();
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = (st_m[c] != 0);
        return v;
    endfunction

    // driver: updates the model from the requirements, then drives one write
    task automatic wr(input int core, input logic [7:0] addr, input logic [63:0] d,
                      input string req);
        logic [NC-1:0] edge_e = '0;
        logic          err_e = 1'b0;
        int            tgt = int'(d[25:16]);
        logic [31:0]   old;
        case (addr)
            8'h08, 8'h0C: begin
                old = st_m[core];
                if (addr == 8'h08) st_m[core] = old | d[31:0];
                else               st_m[core] = old & ~d[31:0];
                edge_e[core] = (old == 0) && (st_m[core] != 0);
            end
            8'h10: begin
                if (tgt < NC) begin
                    old = st_m[tgt];
                    st_m[tgt] = old | (32'd1 << d[4:0]);
                    edge_e[tgt] = (old == 0);
                end else err_e = 1'b1;
            end
            8'h18: begin
                if (tgt < NC) begin
                    for (int b = 0; b < 4; b++)
                        if (!d[27+b]) mb_m[tgt][d[4:2]][8*b +: 8] = d[32+8*b +: 8];
                end else err_e = 1'b1;
            end
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b1; wr_core = CW'(core); wr_addr = addr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({req, " irq_edge"}, 64'(irq_edge), 64'(edge_e));
        chk({req, " irq"}, 64'(irq), 64'(irq_model()));
        chk({req, " send_err"}, 64'(send_err), 64'(err_e));
    endtask

    task automatic rd(input int core, input logic [7:0] addr, input string req);
        logic [31:0] e = '0;
        if (addr == 8'h00) e = st_m[core];
        else if (addr >= 8'h20 && addr < 8'h40 && addr[1:0] == 2'b00)
            e = mb_m[core][addr[4:2]];
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(req);
        rd_en = 1'b1; rd_core = CW'(core); rd_addr = addr;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compares read data in the cycle it is valid
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 unexpected read actual=%0h expected=none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, 64'(rd_data), 64'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            st_m[c] = '0;
            for (int i = 0; i < 8; i++) mb_m[c][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", 64'(irq), 0);
        chk("R1 irq_edge", 64'(irq_edge), 0);
        chk("R1 send_err", 64'(send_err), 0);
        for (int c = 0; c < NC; c++) rd(c, 8'h00, "R1 status");
        rd(3, 8'h3C, "R1 mailbox");
        // R2 R3 R4: signal-send to a zero status, then to a nonzero one
        wr(0, 8'h10, cmd(2, 4'h0, 5'd5, 32'hDEAD_BEEF), "R2 R4 first send");
        rd(2, 8'h00, "R2 status after send");
        wr(0, 8'h10, cmd(2, 4'h0, 5'd9, 32'h0), "R4 send on nonzero");
        rd(2, 8'h00, "R2 second vector");
        // R5: set from issuing core, empty set gives no event
        wr(1, 8'h08, {32'hFFFF_FFFF, 32'h8000_0001}, "R5 set");
        wr(1, 8'h08, 64'h0, "R5 empty set");
        rd(1, 8'h00, "R5 status");
        // R6: clear own bits only
        wr(2, 8'h0C, 64'h20, "R6 clear one bit");
        rd(2, 8'h00, "R6 status");
        rd(1, 8'h00, "R6 other core untouched");
        wr(2, 8'h0C, 64'hFFFF_FFFF, "R3 R6 clear all");
        rd(2, 8'h00, "R6 status zero");
        // R7 R8: mailbox deposit with byte keep
        wr(0, 8'h18, cmd(3, 4'h0, 5'd5 << 2, 32'hA1B2_C3D4), "R7 mail full");
        rd(3, 8'h34, "R7 mailbox 5");
        wr(0, 8'h18, cmd(3, 4'b0101, 5'd5 << 2, 32'h1122_3344), "R8 mail keep 0101");
        rd(3, 8'h34, "R8 kept bytes");
        wr(0, 8'h18, cmd(3, 4'hF, 5'd5 << 2, 32'h5555_5555), "R8 keep all");
        rd(3, 8'h34, "R8 unchanged");
        wr(1, 8'h18, cmd(0, 4'b1000, 5'd7 << 2, 32'h0102_0304), "R7 mail idx 7");
        rd(0, 8'h3C, "R7 mailbox 7");
        wr(1, 8'h18, cmd(0, 4'h0, 5'd0, 32'hCAFE_F00D), "R7 mail idx 0");
        rd(0, 8'h20, "R7 mailbox 0");
        rd(3, 8'h30, "R7 neighbour word untouched");
        // R9: absent targets
        wr(0, 8'h10, cmd(7, 4'h0, 5'd3, 32'h0), "R9 signal-send bad target");
        wr(0, 8'h18, cmd(4, 4'h0, 5'd1 << 2, 32'h7777_7777), "R9 mail bad target");
        wr(0, 8'h10, cmd(1023, 4'h0, 5'd0, 32'h0), "R9 max target");
        for (int c = 0; c < NC; c++) rd(c, 8'h00, "R9 status unchanged");
        rd(0, 8'h24, "R9 mailbox unchanged");
        // R2: every vector into core 0
        for (int v = 0; v < 32; v++)
            wr(3, 8'h10, cmd(0, 4'h0, 5'(v), 32'h0), "R2 vector sweep");
        rd(0, 8'h00, "R2 all vectors");
        // R10: unmapped and misaligned addresses
        rd(0, 8'h04, "R10 unmapped");
        rd(3, 8'h35, "R10 misaligned");
        rd(0, 8'h40, "R10 past mailbox");
        repeat (3) @(negedge clk);
        chk("R10 reads drained", 64'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule